// File: doc/BRIEF.md
# Single-Clock Queue with Look-Ahead Read Mode

This block is a first-in/first-out queue whose producer and consumer share one clock. Words are stored in an inferred RAM array, and every RAM location holds data: no slot is kept back to tell full from empty. An occupancy counter separates those two states instead. The queue reports full and empty, plus an almost-full and an almost-empty level, and each threshold is a parameter.

The `fwftMode` input chooses how the queue is read. It is static and may only change while reset is held. In standard mode a read request loads the oldest word into the output register, and the word is visible one cycle later. In look-ahead mode the oldest word is fetched into the output register before anyone asks for it. It stays on `rdData` for as long as `empty` is low, and a read request moves on to the next word. That output register also counts as storage, so the queue holds one word more than the RAM depth.

Top module: `sync_fifo`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the queue resets: `empty`=1, `progEmpty`=1, `full`=0, `progFull`=0 and `rdData`=0.
- R2: In standard mode (`fwftMode`=0), a read accepted at a clock edge places the oldest stored word on `rdData` after that same edge. `rdData` holds its value in every cycle without an accepted read. Words leave in the order they were written.
- R3: In standard mode, capacity is DEPTH words. `full` rises after the edge that stores word DEPTH and stays low before it. `full` and `empty` are never high together.
- R4: In look-ahead mode (`fwftMode`=1), a word written into an empty queue shows on `rdData`, with `empty` low, after the second edge following the write, with no read request. The head word stays stable while `rdEn` is low.
- R5: In look-ahead mode, capacity is DEPTH+1 words. `full` rises only after word DEPTH+1 is stored. Draining returns every word in write order.
- R6: A write while `full` is high is ignored. The queue stays full, and the words already stored read back unchanged.
- R7: A read while `empty` is high is ignored. The queue stays empty, and in standard mode `rdData` keeps its value.
- R8: A read and a write accepted in the same cycle leave the occupancy unchanged, so `full`, `progFull` and `progEmpty` keep their values, and order is preserved.
- R9: `progFull` is high exactly when the occupancy is at least PROG_FULL_TH. It is updated at the edge that changes the occupancy.
- R10: `progEmpty` is high exactly when the occupancy is at most PROG_EMPTY_TH. It is updated at the edge that changes the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| fwftMode | input | 1 | 1 = look-ahead read, 0 = standard read; change only under reset |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| full | output | 1 | Occupancy equals capacity |
| progFull | output | 1 | Occupancy at or above PROG_FULL_TH |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Output register: read word (standard) or head word (look-ahead) |
| empty | output | 1 | No word available to read |
| progEmpty | output | 1 | Occupancy at or below PROG_EMPTY_TH |

## Verification
In standard mode the queue is driven with a short mixed sequence of writes, reads, simultaneous read and write, and reads on an empty queue. This shows one-cycle read latency, correct ordering, and that ignored reads cause no harm. A full fill followed by a full drain, once in each mode, exposes an off-by-one in capacity (DEPTH against DEPTH+1) and a misplaced threshold edge on either almost flag. A write into a full queue, followed by readback, separates a properly blocked write from one that overwrites the oldest word. In look-ahead mode, a write into an empty queue and a combined read and write on a single word test whether the head word appears without a request, and on which edge it appears.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Strobes issued by the control to the storage datapath
  typedef struct packed {
    logic ramWe;  // store wrData at the write pointer
    logic ramRe;  // load output register from the read pointer
  } strobes_t;
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int DEPTH        = 16,
  parameter int PROG_FULL_TH = 14,
  parameter int PROG_EMPTY_TH = 2,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fwftMode,
  input  logic                wrEn,
  input  logic                rdEn,
  output fifo_pkg::strobes_t  strb,
  output logic [ADDR_W-1:0]   wrPtr,
  output logic [ADDR_W-1:0]   rdPtr,
  output logic                full,
  output logic                empty,
  output logic                progFull,
  output logic                progEmpty
);
  localparam logic [CNT_W-1:0] RAM_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PF_LVL  = CNT_W'(PROG_FULL_TH);
  localparam logic [CNT_W-1:0] PE_LVL  = CNT_W'(PROG_EMPTY_TH);

  logic [CNT_W-1:0] ramCount;
  logic [CNT_W-1:0] occupancy;
  logic [CNT_W-1:0] capacity;
  logic             outValid;
  logic             wrAccept;
  logic             rdAccept;
  logic             ramRead;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    occupancy = ramCount + {{(CNT_W-1){1'b0}}, fwftMode & outValid};
    capacity  = RAM_MAX + {{(CNT_W-1){1'b0}}, fwftMode};
    full      = (occupancy == capacity);
    empty     = fwftMode ? !outValid : (ramCount == '0);
    progFull  = (occupancy >= PF_LVL);
    progEmpty = (occupancy <= PE_LVL);
    wrAccept  = wrEn && !full;
    rdAccept  = rdEn && !empty;
    // Look-ahead: refill the output register whenever it is free or being taken
    ramRead   = fwftMode ? ((ramCount != '0) && (!outValid || rdAccept)) : rdAccept;
    strb.ramWe = wrAccept;
    strb.ramRe = ramRead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      ramCount <= '0;
      outValid <= 1'b0;
    end else begin
      if (wrAccept) wrPtr <= advance(wrPtr);
      if (ramRead)  rdPtr <= advance(rdPtr);
      case ({wrAccept, ramRead})
        2'b10:   ramCount <= ramCount + 1'b1;
        2'b01:   ramCount <= ramCount - 1'b1;
        default: ramCount <= ramCount;
      endcase
      if (ramRead)       outValid <= fwftMode;
      else if (rdAccept) outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  fifo_pkg::strobes_t strb,
  input  logic [ADDR_W-1:0]  wrPtr,
  input  logic [ADDR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] memArray [DEPTH];

  // Read-before-write: a load on the slot being written sees the old word
  always_ff @(posedge clk) begin
    if (strb.ramWe) memArray[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.ramRe) rdData <= memArray[rdPtr];
  end
endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int PROG_FULL_TH  = 14,
  parameter int PROG_EMPTY_TH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwftMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  output logic              progFull,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              progEmpty
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  fifo_pkg::strobes_t strb;
  logic [ADDR_W-1:0]  wrPtr;
  logic [ADDR_W-1:0]  rdPtr;

  fifo_ctrl #(
    .DEPTH(DEPTH), .PROG_FULL_TH(PROG_FULL_TH), .PROG_EMPTY_TH(PROG_EMPTY_TH)
  ) u_ctrl (
    .clk(clk), .rst(rst), .fwftMode(fwftMode), .wrEn(wrEn), .rdEn(rdEn),
    .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full), .empty(empty),
    .progFull(progFull), .progEmpty(progEmpty)
  );

  fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/fifo_checker.sv
module fifo_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fwftMode,
  input logic              wrEn,
  input logic              rdEn,
  input logic              full,
  input logic              empty,
  input logic              progFull,
  input logic              progEmpty,
  input logic [DATA_W-1:0] rdData
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (empty && progEmpty && !full && !progFull));

  p_std_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!fwftMode && !(rdEn && !empty)) |=> $stable(rdData));

  p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_head_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fwftMode && !empty && !rdEn) |=> (!empty && $stable(rdData)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn && !rdEn) |=> full);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (!fwftMode && empty && rdEn && !wrEn) |=> (empty && $stable(rdData)));

  p_rdwr_level_r8: assert property (@(posedge clk) disable iff (rst)
    (!full && !empty && wrEn && rdEn) |=> $stable({full, progFull, progEmpty}));
endmodule

bind sync_fifo fifo_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .fwftMode(fwftMode), .wrEn(wrEn), .rdEn(rdEn),
  .full(full), .empty(empty), .progFull(progFull), .progEmpty(progEmpty),
  .rdData(rdData)
);

// File: tb/tb_sync_fifo.sv
`timescale 1ns/1ps
module tb_sync_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int PF = 14;
  localparam int PE = 2;
  localparam int NVEC = 10;

  // {wr, rd, din, expEmpty, expFull, expProgEmpty, expData}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'hA2, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'hA3, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b1, 1'b1, 8'hA4, 1'b0, 1'b0, 1'b1, 8'hA2},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA3},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA4},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA4},
    {1'b1, 1'b0, 8'hB5, 1'b0, 1'b0, 1'b1, 8'hA4},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hB5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwftMode = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic full, progFull, empty, progEmpty;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sync_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .PROG_FULL_TH(PF), .PROG_EMPTY_TH(PE)) dut (
    .clk(clk), .rst(rst), .fwftMode(fwftMode), .wrEn(wrEn), .wrData(wrData),
    .full(full), .progFull(progFull), .rdEn(rdEn), .rdData(rdData),
    .empty(empty), .progEmpty(progEmpty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge
  task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r);
    @(negedge clk);
    wrEn = w; wrData = d; rdEn = r;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rst = 1'b1; fwftMode = mode; wrEn = 1'b0; rdEn = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 empty", 32'(empty), 1); chk("R1 progEmpty", 32'(progEmpty), 1);
    chk("R1 full", 32'(full), 0);   chk("R1 progFull", 32'(progFull), 0);
    chk("R1 rdData", 32'(rdData), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runAll();
    // Standard mode vector table: R2, R7, R8, R10
    doReset(1'b0);
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][20], VEC[i][18:11], VEC[i][19]);
      chk("R2/R7/R8 empty", 32'(empty), 32'(VEC[i][10]));
      chk("R3 full", 32'(full), 32'(VEC[i][9]));
      chk("R10 progEmpty", 32'(progEmpty), 32'(VEC[i][8]));
      chk("R2 rdData", 32'(rdData), 32'(VEC[i][7:0]));
    end

    // Standard fill and drain: R3, R6, R9, R10
    doReset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b1, DW'(i + 8'h20), 1'b0);
      chk("R3 full on fill", 32'(full), 32'(i + 1 == DEPTH));
      chk("R9 progFull on fill", 32'(progFull), 32'(i + 1 >= PF));
    end
    cyc(1'b1, 8'hFF, 1'b0);
    chk("R6 full after blocked write", 32'(full), 1);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R6 R2 drain data", 32'(rdData), 32'(i + 8'h20));
      chk("R10 progEmpty on drain", 32'(progEmpty), 32'(DEPTH - 1 - i <= PE));
      chk("R9 progFull on drain", 32'(progFull), 32'(DEPTH - 1 - i >= PF));
    end
    chk("R3 empty after drain", 32'(empty), 1);

    // Look-ahead mode: R4, R5, R6, R7, R8
    doReset(1'b1);
    cyc(1'b1, 8'h40, 1'b0);
    chk("R4 not yet visible", 32'(empty), 1);
    cyc(1'b0, '0, 1'b0);
    chk("R4 head visible", 32'(empty), 0);
    chk("R4 head data", 32'(rdData), 32'h40);
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(1'b1, DW'(8'h40 + i), 1'b0);
      chk("R5 full on fill", 32'(full), 32'(i == DEPTH));
      chk("R9 progFull look-ahead", 32'(progFull), 32'(i + 1 >= PF));
    end
    cyc(1'b1, 8'hEE, 1'b0);
    chk("R6 look-ahead full held", 32'(full), 1);
    chk("R4 head held", 32'(rdData), 32'h40);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R5 drain order", 32'(rdData), 32'(8'h40 + i));
      cyc(1'b0, '0, 1'b1);
    end
    chk("R5 empty after drain", 32'(empty), 1);
    cyc(1'b0, '0, 1'b1);
    chk("R7 look-ahead read on empty", 32'(empty), 1);
    cyc(1'b1, 8'h60, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk("R4 head 60", 32'(rdData), 32'h60);
    cyc(1'b1, 8'h61, 1'b1);
    cyc(1'b0, '0, 1'b0);
    chk("R8 look-ahead rd+wr head", 32'(rdData), 32'h61);
    chk("R8 look-ahead rd+wr nonempty", 32'(empty), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        #4ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule